// File: doc/BRIEF.md
# I2C Register-Mapped Target

This block is the target side of an I2C bus. It answers to a single fixed 7-bit device address and lets a bus controller write and read a small bank of byte-wide registers. Both bus lines arrive as inputs and are oversampled by a system clock that is much faster than the bus. The block never drives a line high. It pulls SDA low through a single drive-low enable and has no SCL output, so it never stretches the clock.

A write transaction begins with the address byte (direction bit 0). The next byte loads the register pointer, and each byte after that is stored at the pointer, which then advances. A read transaction (direction bit 1) returns bytes starting at the current pointer, and the pointer advances after each byte. The pointer holds its value between transactions, so a controller can set it in a write and read from it after a repeated start or after a stop. The full register contents are also driven on a flat output for the surrounding chip logic.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is applied and after it is released, the block does not pull SDA low, and every register reads 0x00.
- R2: A start is SDA falling while SCL is high. After it, the first byte is received MSB first, with the 7-bit address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). When the address equals DEV_ADDR, the block pulls SDA low during the ninth clock as an ACK.
- R3: In a write, the first byte after the address loads the register pointer. Each later byte is stored at the pointer, the pointer then advances by one, and each of these bytes is ACKed.
- R4: The pointer is loaded with the received byte modulo NUM_REGS (16 by default). It wraps from NUM_REGS-1 to 0, for both writes and reads.
- R5: In a read, the block sends the register at the pointer MSB first and then releases SDA for the controller's acknowledge bit. After an ACK (SDA low), it sends the next register.
- R6: The pointer value is kept across a repeated start and across a stop. A write that sets the pointer, followed by a read, returns the registers from that pointer.
- R7: When the address does not match, the block sends no ACK and keeps SDA released for the rest of the transaction. Data bytes in that transaction change no register.
- R8: A NACK (SDA high) from the controller after a read byte ends the transmission. SDA stays released for any further clocks until the next start or stop.
- R9: A stop is SDA rising while SCL is high. It returns the block to idle, discards a partly received byte, and the next start is handled as a new transaction.
- R10: The block changes its SDA drive only while SCL is low.
- R11: Transfers work at bus rates of about 400 kHz and 100 kHz with a 125 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*8 | All registers, register k in bits 8k+7..8k |

## Verification
The bench tests the block with several kinds of transaction:
- A burst write with the pointer in the middle of the bank. This shows whether the first byte is treated as the pointer or as data.
- A combined write-then-read across a repeated start, and a read after a stop. These show whether the pointer survives each kind of turnaround.
- A pointer byte above the bank size, with writes and reads that cross the last register. This shows both the modulo load and the wrap.
- A foreign address, a controller NACK followed by extra clocks, and a stop in the middle of a byte. These show that the block stays silent when it should, and that it discards partial data.
- One write at the slower bus rate, to confirm that the timing does not depend on the bus speed.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } slv_state_e;

    localparam int BYTE_W = 8;
    localparam int BITS_PER_BYTE = 8;

endpackage

// File: rtl/i2cs_linesync.sv
module i2cs_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Idle bus level is high, so reset to ones to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign level_o = sync_q[STAGES-1];
    assign rise_o  = sync_q[STAGES-1] & ~last_q;
    assign fall_o  = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [IDX_W-1:0]      waddr_i,
    input  logic [7:0]            wdata_i,
    input  logic [IDX_W-1:0]      raddr_i,
    output logic [7:0]            rdata_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] mem_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we_i && (waddr_i == IDX_W'(g))) begin
                mem_q[g] <= wdata_i;
            end
        end
        assign regs_o[g*8 +: 8] = mem_q[g];
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BITS_PER_BYTE);

    typedef struct packed {
        slv_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [IDX_W-1:0]  ptr;
        logic              first;
        logic              rd;
        logic              nack;
        logic              oe;
    } ctx_t;

    // Line conditioning: one synchronizer per bus line
    logic [1:0] lvl, rise, fall;
    logic [1:0] line_in;
    assign line_in = {sda_i, scl_i};

    for (genvar i = 0; i < 2; i++) begin : g_line
        i2cs_linesync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line_in[i]),
            .level_o (lvl[i]),
            .rise_o  (rise[i]),
            .fall_o  (fall[i])
        );
    end

    logic scl_lvl, scl_rise, scl_fall, sda_lvl;
    logic start_det, stop_det;
    assign scl_lvl   = lvl[0];
    assign scl_rise  = rise[0];
    assign scl_fall  = fall[0];
    assign sda_lvl   = lvl[1];
    assign start_det = scl_lvl & ~scl_rise & fall[1];
    assign stop_det  = scl_lvl & ~scl_rise & rise[1];

    // Register bank
    ctx_t              q, d;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_byte;

    i2cs_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (q.ptr),
        .wdata_i (q.sh),
        .raddr_i (q.ptr),
        .rdata_o (rd_byte),
        .regs_o  (regs_o)
    );

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Next-state logic
    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_det) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.nack = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise && q.cnt < FULL_CNT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL_CNT) begin
                        if (q.sh[7:1] == DEV_ADDR) begin
                            d.rd = q.sh[0];
                            d.oe = 1'b1;
                            d.st = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.sh = rd_byte;
                            d.oe = ~rd_byte[7];
                            d.st = ST_RD;
                        end else begin
                            d.oe    = 1'b0;
                            d.first = 1'b1;
                            d.st    = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise && q.cnt < FULL_CNT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL_CNT) begin
                        d.oe    = 1'b1;
                        d.st    = ST_WR_ACK;
                        d.first = 1'b0;
                        if (q.first) begin
                            d.ptr = q.sh[IDX_W-1:0];
                        end else begin
                            wr_en = 1'b1;
                            d.ptr = next_idx(q.ptr);
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise && q.cnt < FULL_CNT) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == FULL_CNT) begin
                            d.oe   = 1'b0;
                            d.nack = 1'b0;
                            d.ptr  = next_idx(q.ptr);
                            d.st   = ST_RD_ACK;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.nack = sda_lvl;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = ST_SKIP;
                        end else begin
                            d.sh  = rd_byte;
                            d.oe  = ~rd_byte[7];
                            d.cnt = '0;
                            d.st  = ST_RD;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.ptr   <= '0;
            q.first <= 1'b0;
            q.rd    <= 1'b0;
            q.nack  <= 1'b0;
            q.oe    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    slv_state_e st_now;
    assign st_now   = q.st;
    assign sda_oe_o = q.oe;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_lvl,
    input logic       stop_det,
    input slv_state_e st
);
    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe);

    // R10
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // R7
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_oe);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && st == ST_IDLE));

    // R5
    ctrl_ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD_ACK) |-> !sda_oe);
endmodule

bind i2c_regslave i2cs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .scl_lvl  (scl_lvl),
    .stop_det (stop_det),
    .st       (st_now)
);

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;
    localparam logic [6:0] ADDR = 7'h2A;
    localparam int         NREG = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    logic scl_line, sda_line;

    int q_len = 78;
    int checks = 0;
    int errors = 0;
    int oe_hits = 0;
    int scl_high_changes = 0;
    bit finished = 0;
    logic last_oe = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = ~m_scl_low;
    assign sda_line = ~(m_sda_low | sda_oe);

    i2c_regslave #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) u_i2c_regslave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_line),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    // Bench monitors on ports only
    always @(negedge clk) begin
        if (sda_oe) oe_hits++;
        if (sda_oe !== last_oe && scl_line) scl_high_changes++;
        last_oe = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] reg_at(input int k);
        return regs[k*8 +: 8];
    endfunction

    task automatic m_start();
        m_sda_low = 1'b1; tick(q_len);
        m_scl_low = 1'b1; tick(q_len);
    endtask

    task automatic m_rstart();
        m_sda_low = 1'b0; tick(q_len);
        m_scl_low = 1'b0; tick(q_len);
        m_sda_low = 1'b1; tick(q_len);
        m_scl_low = 1'b1; tick(q_len);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; tick(q_len);
        m_scl_low = 1'b0; tick(q_len);
        m_sda_low = 1'b0; tick(q_len);
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda_low = ~b; tick(q_len);
        m_scl_low = 1'b0; tick(q_len);
        r = sda_line; tick(q_len);
        m_scl_low = 1'b1; tick(q_len);
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
        m_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic m_rbyte(input logic ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            v[i] = r;
        end
        m_bit(~ack, r);
    endtask

    task automatic t_reset();
        chk("R1 sda released", {31'd0, sda_oe}, 32'd0);
        for (int k = 0; k < NREG; k++) chk("R1 reg zero", {24'd0, reg_at(k)}, 32'd0);
    endtask

    task automatic t_burst_write();
        logic a;
        m_start();
        m_wbyte({ADDR, 1'b0}, a); chk("R2 address ack", {31'd0, a}, 32'd1);
        m_wbyte(8'h03, a);        chk("R3 pointer ack", {31'd0, a}, 32'd1);
        m_wbyte(8'hA1, a);        chk("R3 data ack", {31'd0, a}, 32'd1);
        m_wbyte(8'hB2, a);
        m_wbyte(8'hC3, a);
        m_stop();
        chk("R3 reg3", {24'd0, reg_at(3)}, 32'hA1);
        chk("R3 reg4", {24'd0, reg_at(4)}, 32'hB2);
        chk("R3 reg5", {24'd0, reg_at(5)}, 32'hC3);
        chk("R3 reg2 untouched", {24'd0, reg_at(2)}, 32'h00);
        chk("R3 reg6 untouched", {24'd0, reg_at(6)}, 32'h00);
    endtask

    task automatic t_combined_read();
        logic a;
        logic [7:0] v;
        m_start();
        m_wbyte({ADDR, 1'b0}, a);
        m_wbyte(8'h03, a);
        m_rstart();
        m_wbyte({ADDR, 1'b1}, a); chk("R6 read address ack", {31'd0, a}, 32'd1);
        m_rbyte(1'b1, v);         chk("R5 R6 first byte", {24'd0, v}, 32'hA1);
        m_rbyte(1'b1, v);         chk("R5 second byte", {24'd0, v}, 32'hB2);
        m_rbyte(1'b0, v);         chk("R5 third byte", {24'd0, v}, 32'hC3);
        m_stop();
    endtask

    task automatic t_wrap();
        logic a;
        logic [7:0] v;
        m_start();
        m_wbyte({ADDR, 1'b0}, a);
        m_wbyte(8'h1F, a);
        m_wbyte(8'h11, a);
        m_wbyte(8'h22, a);
        m_stop();
        chk("R4 reg15", {24'd0, reg_at(15)}, 32'h11);
        chk("R4 reg0 wrapped", {24'd0, reg_at(0)}, 32'h22);
        m_start();
        m_wbyte({ADDR, 1'b0}, a);
        m_wbyte(8'h0F, a);
        m_stop();
        m_start();
        m_wbyte({ADDR, 1'b1}, a);
        m_rbyte(1'b1, v); chk("R6 read after stop", {24'd0, v}, 32'h11);
        m_rbyte(1'b0, v); chk("R4 read wrap", {24'd0, v}, 32'h22);
        m_stop();
    endtask

    task automatic t_foreign();
        logic a;
        oe_hits = 0;
        m_start();
        m_wbyte({ADDR ^ 7'h01, 1'b0}, a); chk("R7 no ack", {31'd0, a}, 32'd0);
        m_wbyte(8'h03, a);
        m_wbyte(8'h55, a);
        m_stop();
        chk("R7 sda never pulled", oe_hits, 0);
        chk("R7 reg3 kept", {24'd0, reg_at(3)}, 32'hA1);
        chk("R7 reg4 kept", {24'd0, reg_at(4)}, 32'hB2);
    endtask

    task automatic t_nack();
        logic a;
        logic [7:0] v;
        m_start();
        m_wbyte({ADDR, 1'b0}, a);
        m_wbyte(8'h03, a);
        m_rstart();
        m_wbyte({ADDR, 1'b1}, a);
        m_rbyte(1'b0, v); chk("R8 byte before nack", {24'd0, v}, 32'hA1);
        oe_hits = 0;
        m_rbyte(1'b0, v); chk("R8 bus idle after nack", {24'd0, v}, 32'hFF);
        chk("R8 no drive after nack", oe_hits, 0);
        m_stop();
        m_start();
        m_wbyte({ADDR, 1'b0}, a); chk("R9 new transaction ack", {31'd0, a}, 32'd1);
        m_wbyte(8'h07, a);
        m_wbyte(8'h5A, a);
        m_stop();
        chk("R9 reg7 written", {24'd0, reg_at(7)}, 32'h5A);
    endtask

    task automatic t_stop_mid();
        logic a, r;
        m_start();
        m_wbyte({ADDR, 1'b0}, a);
        m_wbyte(8'h08, a);
        for (int i = 0; i < 4; i++) m_bit(1'b1, r);
        m_stop();
        chk("R9 partial byte dropped", {24'd0, reg_at(8)}, 32'h00);
        m_start();
        m_wbyte({ADDR, 1'b0}, a);
        m_wbyte(8'h08, a);
        m_wbyte(8'h77, a);
        m_stop();
        chk("R9 reg8 after restart", {24'd0, reg_at(8)}, 32'h77);
    endtask

    task automatic t_slow();
        logic a;
        q_len = 312;
        m_start();
        m_wbyte({ADDR, 1'b0}, a); chk("R11 slow address ack", {31'd0, a}, 32'd1);
        m_wbyte(8'h09, a);
        m_wbyte(8'h9C, a);
        m_stop();
        chk("R11 slow reg9", {24'd0, reg_at(9)}, 32'h9C);
        q_len = 78;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(10);
        t_reset();
        t_burst_write();
        t_combined_read();
        t_wrap();
        t_foreign();
        t_nack();
        t_stop_mid();
        t_slow();
        chk("R10 drive changes with scl low", scl_high_changes, 0);
        finished = 1;
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            report();
        end
    end
endmodule